// File: doc/BRIEF.md
# VLIW Program Memory Loader

This block fills a single-port instruction memory that holds 8K words of 128 bits. It accepts two fill paths and drives one write port. The first path is a 32-bit host port. The host addresses the memory as 32-bit words. The two low address bits select a lane within an instruction word, and the upper bits give the instruction word index. Four writes in lane order build one instruction word, and the word is written only when the last lane arrives. The second path is a 64-bit DMA beat stream. After a start request that gives a start address and a word count, every two accepted beats form one instruction word. Successive words go to consecutive addresses.

A mode input places the block in System Mode or Run Mode. In System Mode the host may write directly and may start a DMA load. In Run Mode every host write and every host DMA start is refused and flagged, and only the DSP-side start request can begin a load of a new code segment. The outputs are a registered write strobe, address and data for the memory, a busy level, a done pulse, a sequence-error pulse and an access-violation pulse. The memory itself sits outside the block.

Top module: `pmem_loader`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `pm_we`, `dma_busy`, `dma_done`, `host_seq_err` and `access_viol` are all low.
- R2: `host_addr[1:0]` is the lane and `host_addr[14:2]` is the word index. Lane 0 fills `pm_wdata[31:0]`, lane 1 fills [63:32], lane 2 fills [95:64] and lane 3 fills [127:96]. In System Mode (`run_mode`=0) with DMA idle, accepted writes to lanes 0,1,2,3 of the same index give exactly one `pm_we` cycle, one clock after the lane-3 write, with `pm_addr` equal to the index and the assembled data on `pm_wdata`.
- R3: Host writes to lanes 0 to 2 never assert `pm_we` by themselves. Idle cycles between the lanes of a word are allowed.
- R4: A host write whose lane is not the expected next lane, or whose index differs from the lane-0 index of the word being built, is discarded. It pulses `host_seq_err` for one cycle, one clock later, and it also discards the partial word. The next word must then start again at lane 0.
- R5: A host write while `run_mode`=1 is dropped and pulses `access_viol` one clock later. It changes no memory word, and it does not disturb a partial host word.
- R6: A host write while `dma_busy` is high is dropped and pulses `access_viol` one clock later. It produces no host commit.
- R7: A DMA load starts, with `dma_busy` high one clock later, only when the block is idle and `dma_word_count` is nonzero, and only on either `host_dma_start` with `run_mode`=0 or `dsp_dma_start` with `run_mode`=1. A `host_dma_start` in Run Mode pulses `access_viol` and starts nothing. A `dsp_dma_start` in System Mode, or a start with a zero count, is ignored.
- R8: While busy, the first accepted beat (`dma_beat_valid`=1) fills bits [63:0] and the second fills [127:64]. One clock after the second beat, `pm_we` is high and `pm_addr` equals the start address plus the number of words already written. Beats with `dma_beat_valid`=0 are ignored.
- R9: `dma_busy` stays high until the last word's second beat is accepted. In the next cycle `dma_busy` is low, the final `pm_we` is high, and `dma_done` is high for exactly that one cycle.
- R10: The DMA write address wraps from 8191 to 0.
- R11: A start request while `dma_busy` is high is ignored. The running load keeps its addresses and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1 = Run Mode, 0 = System Mode |
| host_wr_en | input | 1 | Host 32-bit write strobe |
| host_addr | input | 15 | Host address in 32-bit words: index in [14:2], lane in [1:0] |
| host_wdata | input | 32 | Host write data |
| host_dma_start | input | 1 | Host DMA start request |
| dsp_dma_start | input | 1 | DSP DMA start request |
| dma_start_addr | input | 13 | First instruction word address of the load |
| dma_word_count | input | 14 | Number of instruction words to load |
| dma_beat_valid | input | 1 | DMA beat present |
| dma_beat_data | input | 64 | DMA beat payload |
| pm_we | output | 1 | Memory write strobe |
| pm_addr | output | 13 | Memory write address |
| pm_wdata | output | 128 | Memory write data |
| dma_busy | output | 1 | DMA load in progress |
| dma_done | output | 1 | One-cycle pulse with the final DMA word write |
| host_seq_err | output | 1 | One-cycle pulse: host lane sequence broken |
| access_viol | output | 1 | One-cycle pulse: host access refused |

## Verification
A lane counter that has drifted shows up one clock after the next host write. Either `host_seq_err` pulses when it should not, or the expected `pm_we` is missing. A beat phase held wrongly shows the two 64-bit halves swapped, or taken from the wrong beats, on the very next DMA commit. A remaining-word count that is off by one moves the fall of `dma_busy` and the `dma_done` pulse one word early or late. A broken mode gate shows at once as a write that should not happen, or as a missing or extra `access_viol` pulse. A reference model compares every output port on every clock, so each of these faults is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/pmem_loader_pkg.sv
package pmem_loader_pkg;
  // default geometry of the instruction store and its fill paths
  localparam int unsigned PM_AW_DEF    = 13;
  localparam int unsigned PM_WORD_DEF  = 128;
  localparam int unsigned HOST_DW_DEF  = 32;
  localparam int unsigned DMA_DW_DEF   = 64;

  // number of sub-words of width sub_w inside a word of width word_w
  function automatic int unsigned parts_of(input int unsigned word_w, input int unsigned sub_w);
    return word_w / sub_w;
  endfunction
endpackage

// File: rtl/pmem_access_gate.sv
module pmem_access_gate #(
  parameter int unsigned CW = 14
) (
  input  logic          run_mode,
  input  logic          busy,
  input  logic          host_wr_en,
  input  logic          host_dma_start,
  input  logic          dsp_dma_start,
  input  logic [CW-1:0] word_count,
  output logic          host_wr_ok,
  output logic          dma_go,
  output logic          viol
);
  logic start_req;

  always_comb begin
    // host writes only in System Mode and only while the port is not owned by DMA
    host_wr_ok = host_wr_en && !run_mode && !busy;
    // each requester may start a load only in its own mode
    start_req  = (host_dma_start && !run_mode) || (dsp_dma_start && run_mode);
    dma_go     = start_req && !busy && (word_count != '0);
    viol       = (host_wr_en && (run_mode || busy)) || (host_dma_start && run_mode);
  end
endmodule

// File: rtl/pmem_host_packer.sv
module pmem_host_packer #(
  parameter int unsigned AW     = 13,
  parameter int unsigned WORD_W = 128,
  parameter int unsigned HOST_W = 32,
  localparam int unsigned LANES = WORD_W / HOST_W,
  localparam int unsigned LB    = $clog2(LANES),
  localparam int unsigned HAW   = AW + LB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [HAW-1:0]    addr,
  input  logic [HOST_W-1:0] wdata,
  output logic              commit,
  output logic [AW-1:0]     commit_addr,
  output logic [WORD_W-1:0] commit_data,
  output logic              seq_err
);
  logic [LB-1:0]     exp_lane;
  logic [AW-1:0]     base_idx;
  logic [LB-1:0]     lane;
  logic [AW-1:0]     idx;
  logic              in_seq;
  logic [HOST_W-1:0] lane_q [LANES-1];

  always_comb begin
    lane        = addr[LB-1:0];
    idx         = addr[HAW-1:LB];
    in_seq      = (lane == exp_lane) && ((exp_lane == '0) || (idx == base_idx));
    seq_err     = wr_ok && !in_seq;
    commit      = wr_ok && in_seq && (lane == LB'(LANES-1));
    commit_addr = idx;
  end

  // partial lanes held without reset; the top lane comes straight from the bus
  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_ok && in_seq && (lane == LB'(g)))
        lane_q[g] <= wdata;
    end
    assign commit_data[g*HOST_W +: HOST_W] = lane_q[g];
  end
  assign commit_data[(LANES-1)*HOST_W +: HOST_W] = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_lane <= '0;
      base_idx <= '0;
    end else if (wr_ok) begin
      if (!in_seq) begin
        exp_lane <= '0;
      end else begin
        exp_lane <= exp_lane + 1'b1;
        if (lane == '0)
          base_idx <= idx;
      end
    end
  end

  // after a broken sequence the packer must expect lane 0 again
  assert_restart_after_err_R4 : assert property (@(posedge clk) disable iff (rst)
    seq_err |=> (exp_lane == '0));
endmodule

// File: rtl/pmem_dma_packer.sv
module pmem_dma_packer #(
  parameter int unsigned AW     = 13,
  parameter int unsigned WORD_W = 128,
  parameter int unsigned DMA_W  = 64,
  localparam int unsigned BEATS = WORD_W / DMA_W,
  localparam int unsigned BB    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [AW-1:0]     start_addr,
  input  logic [CW-1:0]     word_count,
  input  logic              beat_valid,
  input  logic [DMA_W-1:0]  beat_data,
  output logic              busy,
  output logic              commit,
  output logic              last,
  output logic [AW-1:0]     commit_addr,
  output logic [WORD_W-1:0] commit_data
);
  logic              busy_q;
  logic [BB-1:0]     beat_q;
  logic [AW-1:0]     addr_q;
  logic [CW-1:0]     remain_q;
  logic              take;
  logic [DMA_W-1:0]  beat_reg [BEATS-1];

  always_comb begin
    take        = busy_q && beat_valid;
    commit      = take && (beat_q == BB'(BEATS-1));
    last        = commit && (remain_q == CW'(1));
    commit_addr = addr_q;
    busy        = busy_q;
  end

  for (genvar g = 0; g < BEATS - 1; g++) begin : g_beat
    always_ff @(posedge clk) begin
      if (take && (beat_q == BB'(g)))
        beat_reg[g] <= beat_data;
    end
    assign commit_data[g*DMA_W +: DMA_W] = beat_reg[g];
  end
  assign commit_data[(BEATS-1)*DMA_W +: DMA_W] = beat_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      beat_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
    end else if (go) begin
      busy_q   <= 1'b1;
      beat_q   <= '0;
      addr_q   <= start_addr;
      remain_q <= word_count;
    end else if (take) begin
      if (commit) begin
        beat_q   <= '0;
        addr_q   <= addr_q + 1'b1;
        remain_q <= remain_q - 1'b1;
        if (last)
          busy_q <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // a load in flight cannot end without a beat
  assert_busy_holds_R9 : assert property (@(posedge clk) disable iff (rst)
    (busy_q && !beat_valid) |=> busy_q);
endmodule

// File: rtl/pmem_loader.sv
module pmem_loader
  import pmem_loader_pkg::*;
#(
  parameter int unsigned AW     = PM_AW_DEF,
  parameter int unsigned WORD_W = PM_WORD_DEF,
  parameter int unsigned HOST_W = HOST_DW_DEF,
  parameter int unsigned DMA_W  = DMA_DW_DEF,
  localparam int unsigned LANES = parts_of(WORD_W, HOST_W),
  localparam int unsigned LB    = $clog2(LANES),
  localparam int unsigned HAW   = AW + LB,
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_mode,
  input  logic              host_wr_en,
  input  logic [HAW-1:0]    host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_dma_start,
  input  logic              dsp_dma_start,
  input  logic [AW-1:0]     dma_start_addr,
  input  logic [CW-1:0]     dma_word_count,
  input  logic              dma_beat_valid,
  input  logic [DMA_W-1:0]  dma_beat_data,
  output logic              pm_we,
  output logic [AW-1:0]     pm_addr,
  output logic [WORD_W-1:0] pm_wdata,
  output logic              dma_busy,
  output logic              dma_done,
  output logic              host_seq_err,
  output logic              access_viol
);
  logic              busy;
  logic              host_wr_ok;
  logic              dma_go;
  logic              viol_c;
  logic              h_commit;
  logic [AW-1:0]     h_addr;
  logic [WORD_W-1:0] h_data;
  logic              h_err;
  logic              d_commit;
  logic              d_last;
  logic [AW-1:0]     d_addr;
  logic [WORD_W-1:0] d_data;

  pmem_access_gate #(.CW(CW)) u_gate (
    .run_mode       (run_mode),
    .busy           (busy),
    .host_wr_en     (host_wr_en),
    .host_dma_start (host_dma_start),
    .dsp_dma_start  (dsp_dma_start),
    .word_count     (dma_word_count),
    .host_wr_ok     (host_wr_ok),
    .dma_go         (dma_go),
    .viol           (viol_c)
  );

  pmem_host_packer #(.AW(AW), .WORD_W(WORD_W), .HOST_W(HOST_W)) u_host (
    .clk         (clk),
    .rst         (rst),
    .wr_ok       (host_wr_ok),
    .addr        (host_addr),
    .wdata       (host_wdata),
    .commit      (h_commit),
    .commit_addr (h_addr),
    .commit_data (h_data),
    .seq_err     (h_err)
  );

  pmem_dma_packer #(.AW(AW), .WORD_W(WORD_W), .DMA_W(DMA_W)) u_dma (
    .clk         (clk),
    .rst         (rst),
    .go          (dma_go),
    .start_addr  (dma_start_addr),
    .word_count  (dma_word_count),
    .beat_valid  (dma_beat_valid),
    .beat_data   (dma_beat_data),
    .busy        (busy),
    .commit      (d_commit),
    .last        (d_last),
    .commit_addr (d_addr),
    .commit_data (d_data)
  );

  // single registered write port; the two sources never commit together
  always_ff @(posedge clk) begin
    if (rst) begin
      pm_we        <= 1'b0;
      pm_addr      <= '0;
      pm_wdata     <= '0;
      dma_done     <= 1'b0;
      host_seq_err <= 1'b0;
      access_viol  <= 1'b0;
    end else begin
      pm_we        <= h_commit || d_commit;
      dma_done     <= d_last;
      host_seq_err <= h_err;
      access_viol  <= viol_c;
      if (d_commit) begin
        pm_addr  <= d_addr;
        pm_wdata <= d_data;
      end else if (h_commit) begin
        pm_addr  <= h_addr;
        pm_wdata <= h_data;
      end
    end
  end

  assign dma_busy = busy;

  assert_no_dual_commit_R6 : assert property (@(posedge clk) disable iff (rst)
    !(h_commit && d_commit));

  assert_run_host_blocked_R5 : assert property (@(posedge clk) disable iff (rst)
    (run_mode && host_wr_en && !dma_busy) |=> (access_viol && !pm_we));

  assert_done_one_cycle_R9 : assert property (@(posedge clk) disable iff (rst)
    dma_done |=> !dma_done);

  assert_done_ends_busy_R9 : assert property (@(posedge clk) disable iff (rst)
    dma_done |-> (!dma_busy && pm_we));

  assert_busy_needs_start_R7 : assert property (@(posedge clk) disable iff (rst)
    $rose(dma_busy) |-> $past(host_dma_start || dsp_dma_start));
endmodule

// File: tb/pmem_loader_test.sv
module pmem_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8192;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run_mode = 1'b0;
  logic         host_wr_en = 1'b0;
  logic [14:0]  host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic         host_dma_start = 1'b0;
  logic         dsp_dma_start = 1'b0;
  logic [12:0]  dma_start_addr = '0;
  logic [13:0]  dma_word_count = '0;
  logic         dma_beat_valid = 1'b0;
  logic [63:0]  dma_beat_data = '0;
  logic         pm_we;
  logic [12:0]  pm_addr;
  logic [127:0] pm_wdata;
  logic         dma_busy, dma_done, host_seq_err, access_viol;

  int vectors = 0;
  int miscompares = 0;
  bit armed = 1'b0;
  bit finished = 1'b0;
  logic [127:0] act_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmem_loader uut (
    .clk(clk), .rst(rst), .run_mode(run_mode),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_dma_start(host_dma_start), .dsp_dma_start(dsp_dma_start),
    .dma_start_addr(dma_start_addr), .dma_word_count(dma_word_count),
    .dma_beat_valid(dma_beat_valid), .dma_beat_data(dma_beat_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .dma_busy(dma_busy), .dma_done(dma_done),
    .host_seq_err(host_seq_err), .access_viol(access_viol)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_exp_lane, m_base, m_beat, m_addr, m_rem;
  bit m_busy;
  logic [31:0] m_part [4];
  logic [63:0] m_lo;
  bit e_we, e_done, e_err, e_viol, e_busy;
  logic [12:0] e_addr;
  logic [127:0] e_data;
  string e_tag;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      m_exp_lane = 0; m_base = 0; m_beat = 0; m_addr = 0; m_rem = 0; m_busy = 0;
      e_we = 0; e_done = 0; e_err = 0; e_viol = 0; e_busy = 0; e_tag = "R1";
    end else begin
      bit b0;
      b0 = m_busy;
      e_we = 0; e_done = 0; e_err = 0; e_viol = 0;
      if (host_wr_en && (run_mode || b0)) begin
        e_viol = 1;
      end else if (host_wr_en) begin
        int lane, idx;
        lane = int'(host_addr) % 4;
        idx  = int'(host_addr) / 4;
        if (lane == m_exp_lane && (m_exp_lane == 0 || idx == m_base)) begin
          m_part[lane] = host_wdata;
          if (lane == 0) m_base = idx;
          if (lane == 3) begin
            e_we = 1; e_addr = 13'(idx); e_tag = "R2";
            e_data = {m_part[3], m_part[2], m_part[1], m_part[0]};
            m_exp_lane = 0;
          end else m_exp_lane++;
        end else begin
          e_err = 1; m_exp_lane = 0;
        end
      end
      if (host_dma_start && run_mode) e_viol = 1;
      if (b0 && dma_beat_valid) begin
        if (m_beat == 0) begin
          m_lo = dma_beat_data; m_beat = 1;
        end else begin
          e_we = 1; e_addr = 13'(m_addr); e_tag = "R8";
          e_data = {dma_beat_data, m_lo};
          m_addr = (m_addr + 1) % DEPTH; m_rem--; m_beat = 0;
          if (m_rem == 0) begin m_busy = 0; e_done = 1; end
        end
      end else if (!b0 && dma_word_count != 0 &&
                   ((host_dma_start && !run_mode) || (dsp_dma_start && run_mode))) begin
        m_busy = 1; m_addr = int'(dma_start_addr); m_rem = int'(dma_word_count); m_beat = 0;
      end
      e_busy = m_busy;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (armed && !finished) begin
      if (pm_we === 1'b1) act_mem[int'(pm_addr)] = pm_wdata;
      chk(pm_we === e_we, e_we ? e_tag : (rst ? "R1" : "R3 pm_we"), 128'(pm_we), 128'(e_we));
      if (e_we) begin
        chk(pm_addr === e_addr, e_tag, 128'(pm_addr), 128'(e_addr));
        chk(pm_wdata === e_data, e_tag, pm_wdata, e_data);
      end
      chk(dma_done === e_done, "R9 done", 128'(dma_done), 128'(e_done));
      chk(dma_busy === e_busy, "R7 busy", 128'(dma_busy), 128'(e_busy));
      chk(host_seq_err === e_err, "R4 seq_err", 128'(host_seq_err), 128'(e_err));
      chk(access_viol === e_viol, "R5 viol", 128'(access_viol), 128'(e_viol));
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit we, input int a, input logic [31:0] d, input bit hs, input bit ds,
                       input int sa, input int cnt, input bit bv, input logic [63:0] bd);
    @(negedge clk);
    host_wr_en = we; host_addr = 15'(a); host_wdata = d;
    host_dma_start = hs; dsp_dma_start = ds;
    dma_start_addr = 13'(sa); dma_word_count = 14'(cnt);
    dma_beat_valid = bv; dma_beat_data = bd;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] hdat(input int idx, input int lane);
    return 32'hC0DE_0000 ^ 32'(idx << 4) ^ 32'(lane);
  endfunction

  function automatic logic [63:0] ddat(input int n, input int beat);
    return {32'hDA7A_0000 | 32'(n), 32'h0B00_0000 | 32'(beat)};
  endfunction

  function automatic logic [127:0] hword(input int idx);
    return {hdat(idx, 3), hdat(idx, 2), hdat(idx, 1), hdat(idx, 0)};
  endfunction

  task automatic host_wr(input int idx, input int lane, input logic [31:0] d);
    drive(1, idx * 4 + lane, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic host_word(input int idx, input bit gaps);
    for (int l = 0; l < 4; l++) begin
      host_wr(idx, l, hdat(idx, l));
      if (gaps) quiet(1);
    end
  endtask

  task automatic beats(input int n0, input int nwords, input bit gaps);
    for (int k = 0; k < nwords; k++)
      for (int b = 0; b < 2; b++) begin
        drive(0, 0, 0, 0, 0, 0, 0, 1, ddat(n0 + k, b));
        if (gaps) quiet(1);
      end
  endtask

  task automatic settle();
    quiet(2);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk({pm_we, dma_busy, dma_done, host_seq_err, access_viol} === 5'b0, "R1 reset", 128'(pm_we), 128'(0));
    rst = 1'b0;
    quiet(1);
    chk({pm_we, dma_busy, dma_done, host_seq_err, access_viol} === 5'b0, "R1 after", 128'(pm_we), 128'(0));

    // R2 / R3: back-to-back host word
    host_wr(5, 0, hdat(5, 0)); host_wr(5, 1, hdat(5, 1)); host_wr(5, 2, hdat(5, 2));
    quiet(2); #(CLK_PERIOD/4);
    chk(!act_mem.exists(5), "R3 no early write", 0, 0);
    host_wr(5, 3, hdat(5, 3));
    settle();
    chk(act_mem.exists(5) && act_mem[5] === hword(5), "R2 word 5", act_mem.exists(5) ? act_mem[5] : 'x, hword(5));
    host_word(8191, 1);
    settle();
    chk(act_mem.exists(8191) && act_mem[8191] === hword(8191), "R3 gapped word", act_mem.exists(8191) ? act_mem[8191] : 'x, hword(8191));

    // R4: sequence faults
    host_wr(10, 0, 32'h1111_0000); host_wr(10, 2, 32'h2222_0000);
    host_wr(10, 1, 32'h3333_0000);
    host_wr(11, 0, 32'h4444_0000); host_wr(12, 1, 32'h5555_0000);
    host_wr(13, 1, 32'h6666_0000);
    host_word(10, 0);
    settle();
    chk(act_mem.exists(10) && act_mem[10] === hword(10), "R4 restart", act_mem.exists(10) ? act_mem[10] : 'x, hword(10));
    chk(!act_mem.exists(11) && !act_mem.exists(12) && !act_mem.exists(13), "R4 discarded", 0, 0);

    // R5: run-mode host writes and host start refused; partial word survives
    host_wr(30, 0, hdat(30, 0)); host_wr(30, 1, hdat(30, 1));
    @(negedge clk); run_mode = 1'b1;
    host_word(20, 0);
    drive(0, 0, 0, 1, 0, 200, 4, 0, 0);
    settle();
    chk(!act_mem.exists(20), "R5 run write dropped", 0, 0);
    chk(dma_busy === 1'b0, "R7 host start in run", 128'(dma_busy), 0);
    run_mode = 1'b0;
    host_wr(30, 2, hdat(30, 2)); host_wr(30, 3, hdat(30, 3));
    settle();
    chk(act_mem.exists(30) && act_mem[30] === hword(30), "R5 partial kept", act_mem.exists(30) ? act_mem[30] : 'x, hword(30));

    // R7: ignored starts
    drive(0, 0, 0, 0, 1, 300, 2, 0, 0);
    drive(0, 0, 0, 1, 0, 300, 0, 0, 0);
    settle();
    chk(dma_busy === 1'b0, "R7 ignored starts", 128'(dma_busy), 0);

    // R8 / R6 / R11: system-mode DMA with gaps, host write and restart during busy
    drive(0, 0, 0, 1, 0, 100, 3, 0, 0);
    quiet(1);
    #(CLK_PERIOD/4);
    chk(dma_busy === 1'b1, "R7 busy after start", 128'(dma_busy), 1);
    host_word(40, 0);
    drive(0, 0, 0, 1, 0, 500, 5, 0, 0);
    beats(1, 3, 1);
    settle();
    for (int k = 0; k < 3; k++)
      chk(act_mem.exists(100 + k) && act_mem[100 + k] === {ddat(1 + k, 1), ddat(1 + k, 0)}, "R8 dma word",
          act_mem.exists(100 + k) ? act_mem[100 + k] : 'x, {ddat(1 + k, 1), ddat(1 + k, 0)});
    chk(!act_mem.exists(40), "R6 host during busy", 0, 0);
    chk(!act_mem.exists(500), "R11 restart ignored", 0, 0);
    chk(dma_busy === 1'b0, "R9 idle after load", 128'(dma_busy), 0);

    // R10: run-mode DSP load wrapping the address
    @(negedge clk); run_mode = 1'b1;
    drive(0, 0, 0, 0, 1, 8190, 3, 0, 0);
    beats(10, 3, 0);
    settle();
    chk(act_mem.exists(0) && act_mem[0] === {ddat(12, 1), ddat(12, 0)}, "R10 wrap",
        act_mem.exists(0) ? act_mem[0] : 'x, {ddat(12, 1), ddat(12, 0)});
    chk(act_mem.exists(8190) && act_mem[8190] === {ddat(10, 1), ddat(10, 0)}, "R8 dsp load",
        act_mem.exists(8190) ? act_mem[8190] : 'x, {ddat(10, 1), ddat(10, 0)});

    // single-word load, done pulse with final write
    drive(0, 0, 0, 0, 1, 7, 1, 0, 0);
    beats(20, 1, 0);
    quiet(4);
    run_mode = 1'b0;
    quiet(2);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule